// File: doc/BRIEF.md
# Multiple-Bus Two-Level Arbiter

This block arbitrates a shared-memory system in which `N_PROC` processors reach `N_MOD` memory modules over `N_BUS` buses. Every processor and every module sits on every bus. Arbitration is circuit-switched. A processor that wins keeps its bus for a whole access of `ACCESS_CYCLES` cycles, which covers the request, the memory operation and the returned data.

Arbitration runs in two levels within a single cycle:

- **First level.** One bus allocator treats the modules as users and the buses as servers. It hands the free, enabled buses to modules that have at least one pending requester and are not already in an access.
- **Second level.** Each module has its own arbiter, which picks the one processor that proceeds on the bus given to that module. The other requesters of that module wait.

Each processor's request is a valid/ready stream. `req_valid` and `req_mod` are the valid side. `req_ready` is the grant, and `gnt_bus` gives the bus index. A transfer happens when valid and ready are both high. A processor that is not ready must hold `req_valid` high and `req_mod` stable. Back-pressure lasts while its module or every enabled bus is taken. `bus_en` takes a failed bus out of service so the system runs in degraded mode on the rest. With one enabled bus, the block behaves as a single shared bus.

Top module: `multibus_arbiter`

## Requirements
- R1: During and right after reset, all buses are idle and no request is granted.
- R2: `req_ready[p]` goes high only while `req_valid[p]` is high. `gnt_bus` field p (bits p*BUS_W up) then names the granted bus. From the next cycle, that bus reports busy, with owner processor p and module `req_mod` field p.
- R3: In one cycle, at most one processor is granted per module. The other requesters of that module see ready low.
- R4: The number of modules in an access never exceeds min(N_BUS, N_MOD). No more grants than free enabled buses are made in a cycle.
- R5: A bus granted in cycle t reports busy in cycles t+1 through t+ACCESS_CYCLES with a stable owner. It reports idle in cycle t+ACCESS_CYCLES+1, when it may be granted again.
- R6: A bus with `bus_en` low is never granted. An access already running on it completes normally.
- R7: The bus allocator serves requesting modules in round-robin order, starting from the module after the last one it served. After reset it starts at module 0.
- R8: Each module arbiter picks among that module's requesters in round-robin order, starting after the last processor it granted. After reset it starts at processor 0.
- R9: A waiting processor keeps its request, and it is granted once its module and a bus are free.
- R10: A module that is in an access receives no further grant until that access ends.
- R11: The modules chosen in one cycle receive the free enabled buses in ascending bus index, in the order the round-robin visits the modules.
- R12: With exactly one bus enabled, at most one transfer is granted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PROC | Per-processor request valid |
| req_mod | input | N_PROC*MOD_W | Per-processor target module, field p at bit p*MOD_W |
| req_ready | output | N_PROC | Per-processor grant (ready) |
| gnt_bus | output | N_PROC*BUS_W | Granted bus index per processor, meaningful with ready |
| bus_en | input | N_BUS | Bus in service (low = failed bus) |
| bus_busy | output | N_BUS | Bus occupied by an access |
| bus_proc | output | N_BUS*PROC_W | Owning processor per bus |
| bus_mod | output | N_BUS*MOD_W | Owning module per bus |

## Verification
The bench uses the default build: four processors, four modules, two buses and a four-cycle access. With two buses and four modules, a cycle in which every processor requests must leave modules waiting, so the round-robin wrap and the ascending bus assignment both show in one pair of grants. Two buses also let one be switched off during an access and then left off. That exercises the finish of the running access on the disabled bus, the degraded mode, and the single-bus reduction without a second build.

// File: rtl/mba_pkg.sv
package mba_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/mba_mod_arb.sv
// Second level: one processor per module, round-robin.
module mba_mod_arb #(
  parameter int N_PROC = 4,
  parameter int PROC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] want,
  input  logic              take,
  output logic [N_PROC-1:0] pick,
  output logic [PROC_W-1:0] pick_idx
);
  logic [PROC_W-1:0] last_q;
  logic              found;

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < N_PROC; i++) begin
      int c;
      c = (int'(last_q) + 1 + i) % N_PROC;
      if (!found && want[c]) begin
        found       = 1'b1;
        pick[c]     = 1'b1;
        pick_idx    = PROC_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= PROC_W'(N_PROC - 1);
    else if (take) last_q <= pick_idx;
  end

  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $onehot(pick));
  // R8
  winner_wants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pick & ~want) == '0);
endmodule

// File: rtl/mba_bus_alloc.sv
// First level: modules are users, buses are servers, round-robin over modules.
module mba_bus_alloc #(
  parameter int N_MOD = 4,
  parameter int N_BUS = 2,
  parameter int MOD_W = 2,
  parameter int BUS_W = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_MOD-1:0]             want,
  input  logic [N_BUS-1:0]             free,
  output logic [N_MOD-1:0]             served,
  output logic [N_MOD-1:0][BUS_W-1:0]  mod_bus,
  output logic [N_BUS-1:0]             take,
  output logic [N_BUS-1:0][MOD_W-1:0]  bus_mod
);
  logic [MOD_W-1:0]              last_q, last_d;
  logic [N_BUS-1:0][BUS_W-1:0]   free_list;
  int                            nfree;
  int                            used;

  always_comb begin
    free_list = '0;
    nfree     = 0;
    for (int b = 0; b < N_BUS; b++) begin
      if (free[b]) begin
        free_list[nfree] = BUS_W'(b);
        nfree = nfree + 1;
      end
    end
  end

  always_comb begin
    served  = '0;
    mod_bus = '0;
    take    = '0;
    bus_mod = '0;
    last_d  = last_q;
    used    = 0;
    for (int i = 0; i < N_MOD; i++) begin
      int m;
      m = (int'(last_q) + 1 + i) % N_MOD;
      if (want[m] && (used < nfree)) begin
        served[m]                = 1'b1;
        mod_bus[m]               = free_list[used];
        take[free_list[used]]    = 1'b1;
        bus_mod[free_list[used]] = MOD_W'(m);
        last_d                   = MOD_W'(m);
        used                     = used + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= MOD_W'(N_MOD - 1);
    else        last_q <= last_d;
  end

  // R4
  server_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(served) <= $countones(free));
  // R6
  free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~free) == '0);
endmodule

// File: rtl/mba_bus_track.sv
// Per-bus occupancy: holds the owner for a fixed access length.
module mba_bus_track #(
  parameter int ACCESS = 4,
  parameter int PROC_W = 2,
  parameter int MOD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [PROC_W-1:0] proc,
  input  logic [MOD_W-1:0]  mod,
  output logic              busy,
  output logic [PROC_W-1:0] owner_proc,
  output logic [MOD_W-1:0]  owner_mod
);
  localparam int CNT_W = $clog2(ACCESS + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      owner_proc <= '0;
      owner_mod  <= '0;
    end else if (take) begin
      cnt_q      <= CNT_W'(ACCESS);
      owner_proc <= proc;
      owner_mod  <= mod;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R5
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !busy);
  // R2
  owner_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy && owner_proc == $past(proc) && owner_mod == $past(mod));
  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !take |=> $stable(owner_proc) && $stable(owner_mod));
endmodule

// File: rtl/multibus_arbiter.sv
module multibus_arbiter #(
  parameter int N_PROC        = 4,
  parameter int N_MOD         = 4,
  parameter int N_BUS         = 2,
  parameter int ACCESS_CYCLES = 4,
  localparam int PROC_W = mba_pkg::idx_w(N_PROC),
  localparam int MOD_W  = mba_pkg::idx_w(N_MOD),
  localparam int BUS_W  = mba_pkg::idx_w(N_BUS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PROC-1:0]         req_valid,
  input  logic [N_PROC*MOD_W-1:0]   req_mod,
  output logic [N_PROC-1:0]         req_ready,
  output logic [N_PROC*BUS_W-1:0]   gnt_bus,
  input  logic [N_BUS-1:0]          bus_en,
  output logic [N_BUS-1:0]          bus_busy,
  output logic [N_BUS*PROC_W-1:0]   bus_proc,
  output logic [N_BUS*MOD_W-1:0]    bus_mod
);
  localparam int MAX_BUSY = mba_pkg::min_i(N_BUS, N_MOD);

  logic [N_PROC-1:0][MOD_W-1:0]  tgt;
  logic [N_PROC-1:0][BUS_W-1:0]  gb;
  logic [N_BUS-1:0]              busy_v;
  logic [N_BUS-1:0][PROC_W-1:0]  own_p;
  logic [N_BUS-1:0][MOD_W-1:0]   own_m;
  logic [N_PROC-1:0]             proc_held;
  logic [N_MOD-1:0]              mod_held;
  logic [N_PROC-1:0]             elig;
  logic [N_MOD-1:0][N_PROC-1:0]  mreq;
  logic [N_MOD-1:0]              want;
  logic [N_BUS-1:0]              bus_free;
  logic [N_MOD-1:0]              served;
  logic [N_MOD-1:0][BUS_W-1:0]   mod_bus;
  logic [N_BUS-1:0]              bus_take;
  logic [N_BUS-1:0][MOD_W-1:0]   take_mod;
  logic [N_MOD-1:0][N_PROC-1:0]  pick;
  logic [N_MOD-1:0][PROC_W-1:0]  pick_idx;

  assign tgt = req_mod;

  // Who is already inside an access.
  always_comb begin
    proc_held = '0;
    mod_held  = '0;
    for (int b = 0; b < N_BUS; b++) begin
      if (busy_v[b]) begin
        proc_held[own_p[b]] = 1'b1;
        mod_held[own_m[b]]  = 1'b1;
      end
    end
  end

  assign elig = req_valid & ~proc_held;

  always_comb begin
    mreq = '0;
    for (int m = 0; m < N_MOD; m++) begin
      for (int p = 0; p < N_PROC; p++) begin
        mreq[m][p] = elig[p] && (int'(tgt[p]) == m);
      end
    end
  end

  always_comb begin
    for (int m = 0; m < N_MOD; m++) begin
      want[m] = (|mreq[m]) && !mod_held[m];
    end
  end

  assign bus_free = bus_en & ~busy_v;

  mba_bus_alloc #(
    .N_MOD(N_MOD), .N_BUS(N_BUS), .MOD_W(MOD_W), .BUS_W(BUS_W)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n), .want(want), .free(bus_free),
    .served(served), .mod_bus(mod_bus), .take(bus_take), .bus_mod(take_mod)
  );

  for (genvar m = 0; m < N_MOD; m++) begin : g_marb
    mba_mod_arb #(.N_PROC(N_PROC), .PROC_W(PROC_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .want(mreq[m]), .take(served[m]),
      .pick(pick[m]), .pick_idx(pick_idx[m])
    );
  end

  always_comb begin
    req_ready = '0;
    gb        = '0;
    for (int p = 0; p < N_PROC; p++) begin
      if (int'(tgt[p]) < N_MOD) begin
        req_ready[p] = served[tgt[p]] && pick[tgt[p]][p];
        gb[p]        = mod_bus[tgt[p]];
      end
    end
  end

  assign gnt_bus = gb;

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    mba_bus_track #(.ACCESS(ACCESS_CYCLES), .PROC_W(PROC_W), .MOD_W(MOD_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .take(bus_take[b]),
      .proc(pick_idx[take_mod[b]]), .mod(take_mod[b]),
      .busy(busy_v[b]), .owner_proc(own_p[b]), .owner_mod(own_m[b])
    );
  end

  assign bus_busy = busy_v;
  assign bus_proc = own_p;
  assign bus_mod  = own_m;

  // R4
  busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mod_held) <= MAX_BUSY);
  // R12
  single_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_en) == 1 |-> $countones(req_ready) <= 1);

  for (genvar p = 0; p < N_PROC; p++) begin : g_pchk
    // R2
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |-> req_valid[p]);
    // R6
    gnt_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |-> bus_en[gb[p]] && !busy_v[gb[p]]);
    // R10
    gnt_mod_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |-> !mod_held[tgt[p]]);
    // R2
    gnt_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |=> busy_v[$past(gb[p])] && own_p[$past(gb[p])] == PROC_W'(p));
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] && !req_ready[p] |=> req_valid[p] && $stable(tgt[p]));
  end
endmodule

// File: tb/multibus_arbiter_tb.sv
module multibus_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NM = 4;
  localparam int NB = 2;
  localparam int AC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] req_valid;
  logic [NP*2-1:0] req_mod;
  logic [NP-1:0] req_ready;
  logic [NP-1:0] gnt_bus;
  logic [NB-1:0] bus_en;
  logic [NB-1:0] bus_busy;
  logic [NB*2-1:0] bus_proc;
  logic [NB*2-1:0] bus_mod;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multibus_arbiter #(.N_PROC(NP), .N_MOD(NM), .N_BUS(NB), .ACCESS_CYCLES(AC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mod(req_mod),
    .req_ready(req_ready), .gnt_bus(gnt_bus), .bus_en(bus_en),
    .bus_busy(bus_busy), .bus_proc(bus_proc), .bus_mod(bus_mod)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input int p, input int m);
    req_valid[p]       = 1'b1;
    req_mod[p*2 +: 2]  = 2'(m);
  endtask

  task automatic t_reset();
    chk("R1 ready in reset", int'(req_ready), 0);
    chk("R1 busy in reset", int'(bus_busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", int'(req_ready), 0);
    chk("R1 busy after reset", int'(bus_busy), 0);
  endtask

  task automatic t_basic();
    set_req(0, 2);
    #1;
    chk("R2 grant p0", int'(req_ready), 4'b0001);
    chk("R11 p0 lowest bus", int'(gnt_bus[0]), 0);
    tick();
    req_valid[0] = 1'b0;
    for (int k = 0; k < AC; k++) begin
      #1;
      chk("R5 bus0 busy", int'(bus_busy), 2'b01);
      chk("R2 owner proc", int'(bus_proc[1:0]), 0);
      chk("R2 owner mod", int'(bus_mod[1:0]), 2);
      tick();
    end
    #1;
    chk("R5 bus0 released", int'(bus_busy), 0);
  endtask

  task automatic t_conflict();
    set_req(1, 1);
    set_req(3, 1);
    #1;
    chk("R8 rr picks p1", int'(req_ready), 4'b0010);
    tick();
    req_valid[1] = 1'b0;
    for (int k = 0; k < AC; k++) begin
      #1;
      chk("R10 module busy no grant", int'(req_ready), 0);
      tick();
    end
    #1;
    chk("R9 p3 finally granted", int'(req_ready), 4'b1000);
    chk("R3 p3 bus", int'(gnt_bus[3]), 0);
    tick();
    req_valid[3] = 1'b0;
    repeat (AC + 2) tick();
  endtask

  task automatic t_rr();
    for (int p = 0; p < NP; p++) set_req(p, p);
    #1;
    chk("R7 rr serves m2,m3", int'(req_ready), 4'b1100);
    chk("R11 m2 on bus0", int'(gnt_bus[2]), 0);
    chk("R11 m3 on bus1", int'(gnt_bus[3]), 1);
    tick();
    req_valid[2] = 1'b0;
    req_valid[3] = 1'b0;
    for (int k = 0; k < AC; k++) begin
      #1;
      chk("R4 no free bus", int'(req_ready), 0);
      chk("R4 both busy", int'(bus_busy), 2'b11);
      tick();
    end
    #1;
    chk("R7 wrap serves m0,m1", int'(req_ready), 4'b0011);
    chk("R11 m0 on bus0", int'(gnt_bus[0]), 0);
    chk("R11 m1 on bus1", int'(gnt_bus[1]), 1);
    tick();
    req_valid[0] = 1'b0;
    req_valid[1] = 1'b0;
    repeat (AC + 2) tick();
  endtask

  task automatic t_inflight();
    set_req(2, 2);
    set_req(3, 3);
    #1;
    chk("R7 m2,m3 granted", int'(req_ready), 4'b1100);
    chk("R11 p3 on bus1", int'(gnt_bus[3]), 1);
    tick();
    req_valid[2] = 1'b0;
    req_valid[3] = 1'b0;
    bus_en = 2'b01;
    for (int k = 0; k < AC; k++) begin
      #1;
      chk("R6 access completes", int'(bus_busy), 2'b11);
      chk("R6 bus1 owner kept", int'(bus_proc[3:2]), 3);
      tick();
    end
    #1;
    chk("R5 both released", int'(bus_busy), 0);
  endtask

  task automatic t_disabled();
    set_req(0, 0);
    set_req(1, 3);
    #1;
    chk("R12 one grant", int'(req_ready), 4'b0001);
    chk("R6 only bus0", int'(gnt_bus[0]), 0);
    tick();
    req_valid[0] = 1'b0;
    for (int k = 0; k < AC; k++) begin
      #1;
      chk("R6 disabled bus unused", int'(req_ready), 0);
      chk("R6 bus1 idle", int'(bus_busy[1]), 0);
      tick();
    end
    #1;
    chk("R12 p1 on bus0", int'(req_ready), 4'b0010);
    chk("R6 p1 bus index", int'(gnt_bus[1]), 0);
    tick();
    req_valid[1] = 1'b0;
    repeat (AC + 2) tick();
    bus_en = 2'b11;
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = '0;
    req_mod   = '0;
    bus_en    = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    t_basic();
    tick();
    t_conflict();
    t_rr();
    t_inflight();
    tick();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule